// File: doc/BRIEF.md
# Host Parallel Register and Pixel Port

This block is the host-facing side of a display controller: a strobe-driven parallel bus with active-low chip select, a register-select line, and separate write and read strobes. The host first loads a 16-bit index. Data cycles that follow either update the control register the index names or, when the index names pixel memory, move pixel data to and from the graphics memory.

All bus pins are brought into the core clock through a synchronizer, and a transfer takes effect on the rising edge of its strobe. Pixel writes are placed in a one-entry write-data holding register. From there they leave on a valid/ready stream with no further host action. Pixel reads are served through a two-stage read path: a read-data register is filled from memory, and a bus latch is filled from that register. The first read after the pixel index is set therefore returns a stale dummy value, and valid data begins with the second read. A mode pin chooses an 18-bit bus or an 8-bit bus on which every value takes two transfers.

The pixel write stream obeys these rules. `pix_valid` stays high and `pix_data` stays stable until the cycle in which `pix_ready` is seen high. While a pixel is waiting, further pixel writes from the host are discarded, so the host must not outpace the sink. The fetch request `fetch_valid` is held until `fetch_ready`. The fetch response has no ready: the block accepts `rsp_valid` in any cycle.

Top module: `pbus_reg_if`

## Requirements
- R1: After reset `db_oe`, `cfg_wr_en`, `pix_valid` and `fetch_valid` are 0, the index is 0 and the bus read latch holds 0.
- R2: `db_oe` is 1 only while `cs_n` and `rd_n` are both low. While `cs_n` is high, strobes have no effect on the index or on any output.
- R3: A write with `rs` low loads the index. A write with `rs` high, to any index other than 0x0022, gives a single-cycle `cfg_wr_en` carrying that index on `cfg_idx` and the data on `cfg_data`.
- R4: A read with `rs` low returns the fixed identification value 18'h2A5C3.
- R5: A write with `rs` high while the index is 0x0022 raises `pix_valid` with the data on `pix_data`. Both hold until `pix_ready` is high.
- R6: A pixel write that arrives while `pix_valid` is already high is discarded.
- R7: Writing 0x0022 to the index requests one memory fetch. The response loads the read-data register.
- R8: A read with `rs` high at index 0x0022 returns the bus latch. When the read ends, the latch takes the read-data register and a new fetch is requested. The first read after an index write therefore returns stale data.
- R9: With `mode8` high, two write transfers on `db_in[7:0]` (first byte F, second byte S) form one commit. The index becomes {F,S} and the data becomes {F,S,2'b00}. The first transfer commits nothing.
- R10: With `mode8` high, a value is read in two transfers on `db_out[7:0]`: bits 17:10 first, then bits 9:2. `db_out[17:8]` reads 0.
- R11: A read with `rs` high at any index other than 0x0022 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| mode8 | input | 1 | 1 selects the 8-bit bus with two transfers per value |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | 0 selects index/status, 1 selects data |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| db_in | input | 18 | Bus data from the host |
| db_out | output | 18 | Bus data to the host |
| db_oe | output | 1 | Bus output enable |
| cfg_wr_en | output | 1 | Control register write pulse |
| cfg_idx | output | 16 | Control register index |
| cfg_data | output | 18 | Control register data |
| pix_valid | output | 1 | Pixel write stream valid |
| pix_ready | input | 1 | Pixel write stream ready |
| pix_data | output | 18 | Pixel write data |
| fetch_valid | output | 1 | Memory read request |
| fetch_ready | input | 1 | Memory read request accepted |
| rsp_valid | input | 1 | Memory read data valid |
| rsp_data | input | 18 | Memory read data |

## Verification
The bench walks through the read pipeline and checks that the first pixel read after each index write is stale. A design that sent the memory data straight to the bus would return the real pixel one read too early. Pixel writes are sent against a stalled sink: a design that overwrote the held pixel would show the second value, and one that dropped valid early would lose data. Strobes with chip select high are checked for leaking into the index. In 8-bit mode the bench checks that nothing commits after a single byte and that the byte order is right; swapped halves or an early commit would show up on `cfg_data` and `cfg_wr_en`.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned DW_DEF = 18;
  localparam int unsigned IW_DEF = 16;
  localparam logic [15:0] MEM_IDX_DEF = 16'h0022;
  localparam logic [17:0] DEV_ID_DEF = 18'h2A5C3;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int unsigned W = 22,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= RST;
      else if (g == 0) st[g] <= d;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pbus_pack.sv
module pbus_pack #(
  parameter int unsigned DW = 18,
  parameter int unsigned IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode8,
  input  logic          xfer,
  input  logic [DW-1:0] din,
  output logic          done,
  output logic          phase,
  output logic [DW-1:0] word,
  output logic [IW-1:0] idxw
);
  localparam int unsigned BW = 8;
  logic [BW-1:0] hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi    <= '0;
      phase <= 1'b0;
    end else if (xfer && mode8) begin
      if (!phase) hi <= din[BW-1:0];
      phase <= !phase;
    end
  end

  assign done = xfer && (!mode8 || phase);
  assign word = mode8 ? {hi, din[BW-1:0], {(DW-2*BW){1'b0}}} : din;
  assign idxw = mode8 ? IW'({hi, din[BW-1:0]}) : din[IW-1:0];

  // R9: nothing commits after the first byte; the phase flag toggles on every byte
  a_r9_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mode8) |=> (phase != $past(phase)));
endmodule

// File: rtl/pbus_rdpath.sv
module pbus_rdpath #(
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prefetch,
  input  logic          advance,
  output logic          fetch_valid,
  input  logic          fetch_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic [DW-1:0] out_latch
);
  logic [DW-1:0] rdr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_valid <= 1'b0;
      rdr         <= '0;
      out_latch   <= '0;
    end else begin
      if (prefetch || advance) fetch_valid <= 1'b1;
      else if (fetch_ready) fetch_valid <= 1'b0;
      if (rsp_valid) rdr <= rsp_data;
      if (advance) out_latch <= rdr;
    end
  end

  // R7: a pending request is held until accepted
  a_r7_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> fetch_valid);
endmodule

// File: rtl/pbus_reg_if.sv
module pbus_reg_if
  import pbus_pkg::*;
#(
  parameter int unsigned DW = DW_DEF,
  parameter int unsigned IW = IW_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [IW-1:0] MEM_IDX = MEM_IDX_DEF,
  parameter logic [DW-1:0] DEV_ID = DEV_ID_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode8,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] db_in,
  output logic [DW-1:0] db_out,
  output logic          db_oe,
  output logic          cfg_wr_en,
  output logic [IW-1:0] cfg_idx,
  output logic [DW-1:0] cfg_data,
  output logic          pix_valid,
  input  logic          pix_ready,
  output logic [DW-1:0] pix_data,
  output logic          fetch_valid,
  input  logic          fetch_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data
);
  localparam int unsigned SW = DW + 4;
  localparam logic [SW-1:0] SRST = {1'b1, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic [SW-1:0] syn;
  logic          s_cs_n, s_rs, s_wr, s_rd;
  logic [DW-1:0] s_db;
  logic          wr_q, rd_q, wr_rise, rd_rise, xfer;
  logic          done, phase;
  logic [DW-1:0] word, out_latch, rd_val;
  logic [IW-1:0] idxw, idx;
  logic          prefetch, advance;

  pbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST(SRST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rs, wr_n, rd_n, db_in}), .q(syn));

  assign {s_cs_n, s_rs, s_wr, s_rd, s_db} = syn;
  assign wr_rise = !s_cs_n && s_wr && !wr_q;
  assign rd_rise = !s_cs_n && s_rd && !rd_q;
  assign xfer    = wr_rise || rd_rise;

  pbus_pack #(.DW(DW), .IW(IW)) u_pack (
    .clk(clk), .rst_n(rst_n), .mode8(mode8), .xfer(xfer), .din(s_db),
    .done(done), .phase(phase), .word(word), .idxw(idxw));

  assign prefetch = done && wr_rise && !s_rs && (idxw == MEM_IDX);
  assign advance  = done && rd_rise && s_rs && (idx == MEM_IDX);

  pbus_rdpath #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .prefetch(prefetch), .advance(advance),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .out_latch(out_latch));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b1;
      rd_q      <= 1'b1;
      idx       <= '0;
      cfg_wr_en <= 1'b0;
      cfg_idx   <= '0;
      cfg_data  <= '0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      wr_q      <= s_wr;
      rd_q      <= s_rd;
      cfg_wr_en <= 1'b0;
      if (pix_valid && pix_ready) pix_valid <= 1'b0;
      if (done && wr_rise) begin
        if (!s_rs) idx <= idxw;
        else if (idx == MEM_IDX) begin
          if (!pix_valid) begin
            pix_valid <= 1'b1;
            pix_data  <= word;
          end
        end else begin
          cfg_wr_en <= 1'b1;
          cfg_idx   <= idx;
          cfg_data  <= word;
        end
      end
    end
  end

  // bus read path works from the raw pins: the host samples while rd_n is low
  always_comb begin
    if (!rs) rd_val = DEV_ID;
    else if (idx == MEM_IDX) rd_val = out_latch;
    else rd_val = '0;
    db_oe = !cs_n && !rd_n;
    if (!db_oe) db_out = '0;
    else if (mode8) db_out = DW'(phase ? rd_val[9:2] : rd_val[17:10]);
    else db_out = rd_val;
  end

  a_r5_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));
  a_r3_cfg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> !cfg_wr_en);
  a_r3_cfg_not_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |-> (cfg_idx != MEM_IDX));
endmodule

// File: tb/test_pbus_reg_if.sv
module test_pbus_reg_if;
  localparam logic [17:0] ID = 18'h2A5C3;
  localparam logic [15:0] MEMI = 16'h0022;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode8 = 1'b0, cs_n = 1'b1, rs = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [17:0] db_in = '0, db_out, cfg_data, pix_data, rsp_data;
  logic db_oe, cfg_wr_en, pix_valid, fetch_valid, rsp_valid;
  logic pix_ready = 1'b0, fetch_ready = 1'b1;
  logic [15:0] cfg_idx;
  int checks = 0, errors = 0, ncfg = 0, nfetch = 0;
  logic [15:0] last_idx = '0;
  logic [17:0] last_data = '0;

  always #2 clk = !clk;

  pbus_reg_if i_pbus_reg_if (
    .clk(clk), .rst_n(rst_n), .mode8(mode8), .cs_n(cs_n), .rs(rs),
    .wr_n(wr_n), .rd_n(rd_n), .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
    .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  // memory model: the n-th fetch returns 0x100 + n
  always @(posedge clk) begin
    rsp_valid <= fetch_valid && fetch_ready;
    rsp_data  <= 18'h100 + 18'(nfetch);
    if (fetch_valid && fetch_ready) nfetch <= nfetch + 1;
    if (cfg_wr_en) begin
      ncfg <= ncfg + 1;
      last_idx <= cfg_idx;
      last_data <= cfg_data;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic r, logic [17:0] v);
    @(negedge clk); cs_n = 1'b0; rs = r; db_in = v; wr_n = 1'b0;
    repeat (4) @(negedge clk); wr_n = 1'b1;
    repeat (8) @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bread(logic r, output logic [17:0] v);
    @(negedge clk); cs_n = 1'b0; rs = r; rd_n = 1'b0;
    repeat (3) @(negedge clk); v = db_out;
    rd_n = 1'b1;
    repeat (10) @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  localparam logic [33:0] VEC [4] = '{
    {16'h0003, 18'h01030}, {16'h0010, 18'h3FFFF},
    {16'h00A4, 18'h00001}, {16'h0021, 18'h2AAAA}};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] v;
    int c0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", db_oe, 0); chk("R1 cfg", cfg_wr_en, 0);
    chk("R1 pix", pix_valid, 0); chk("R1 fetch", fetch_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 table of control register writes
    for (int k = 0; k < 4; k++) begin
      c0 = ncfg;
      bwrite(1'b0, 18'(VEC[k][33:18]));
      bwrite(1'b1, VEC[k][17:0]);
      chk("R3 count", ncfg - c0, 1);
      chk("R3 idx", last_idx, VEC[k][33:18]);
      chk("R3 data", last_data, VEC[k][17:0]);
    end

    // R2 chip select high: strobes ignored, bus not driven
    @(negedge clk); cs_n = 1'b1; rs = 1'b0; db_in = 18'h00007; wr_n = 1'b0;
    repeat (4) @(negedge clk); wr_n = 1'b1; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 oe with cs high", db_oe, 0);
    rd_n = 1'b1; repeat (10) @(negedge clk);
    c0 = ncfg;
    bwrite(1'b1, 18'h00055);
    chk("R2 index unchanged", last_idx, 16'h0021);
    chk("R2 single commit", ncfg - c0, 1);

    // R4 status read, R11 non-memory data read
    bread(1'b0, v); chk("R4 id", v, ID);
    bread(1'b1, v); chk("R11 zero", v, 0);

    // R7/R8 read pipeline with dummy first read
    bwrite(1'b0, 18'(MEMI));
    chk("R7 fetch issued", nfetch, 1);
    bread(1'b1, v); chk("R8 dummy read", v, 0);
    bread(1'b1, v); chk("R8 second read", v, 18'h100);
    bread(1'b1, v); chk("R8 third read", v, 18'h101);
    bwrite(1'b0, 18'(MEMI));
    bread(1'b1, v); chk("R8 stale after index", v, 18'h102);
    bread(1'b1, v); chk("R8 fresh after index", v, 18'h104);

    // R5/R6 pixel stream under back-pressure
    bwrite(1'b1, 18'h12345);
    chk("R5 valid", pix_valid, 1); chk("R5 data", pix_data, 18'h12345);
    bwrite(1'b1, 18'h0BEEF);
    chk("R6 dropped", pix_data, 18'h12345); chk("R6 valid held", pix_valid, 1);
    @(negedge clk); pix_ready = 1'b1; @(negedge clk); pix_ready = 1'b0;
    chk("R5 released", pix_valid, 0);
    bwrite(1'b1, 18'h00ABC);
    chk("R5 next pixel", pix_data, 18'h00ABC);

    // R9/R10 8-bit mode
    mode8 = 1'b1;
    bwrite(1'b0, 18'h00000); bwrite(1'b0, 18'h00031);
    c0 = ncfg;
    bwrite(1'b1, 18'h000AB);
    chk("R9 no commit after first byte", ncfg - c0, 0);
    bwrite(1'b1, 18'h000CD);
    chk("R9 commit", ncfg - c0, 1);
    chk("R9 idx", last_idx, 16'h0031);
    chk("R9 data", last_data, {8'hAB, 8'hCD, 2'b00});
    bread(1'b0, v); chk("R10 high byte", v, {10'b0, ID[17:10]});
    bread(1'b0, v); chk("R10 low byte", v, {10'b0, ID[9:2]});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule